// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and turns their values into the node's fault confinement state. A receive error counter and a transmit error counter are each moved by single-cycle strobes from the bit stream processor. An increment strobe carries a step-size select, either 1 or a larger penalty step. A decrement always moves by 1. Which protocol event causes which strobe is decided outside this block.

The counter values select one of three states: error-active, error-passive or bus-off. Bus-off is entered when a transmit increment carries the transmit counter past its 8-bit range. Once set, bus-off is latched and freezes both counters. A recovery strobe clears it. The protocol sequencer raises that strobe after it has counted the required recessive idle sequences. The recovery strobe also clears both counters, so the node restarts as error-active.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read 0, `faultState` is 2'b00 (error-active), and `errPassive` and `busOff` are 0.
- R2: Outside bus-off, an increment strobe adds 8 to its counter when its step-select input is 1 and adds 1 when it is 0. The new count appears after the next rising clock edge.
- R3: Outside bus-off, a decrement strobe subtracts 1 from its counter. A counter at 0 stays at 0.
- R4: When the increment and decrement strobes of the same counter are high in the same cycle, the increment is applied and the decrement is ignored.
- R5: The receive counter saturates at 255 and never wraps. An increment that would pass 255 leaves it at 255.
- R6: Outside bus-off, `errPassive` is 1 and `faultState` is 2'b01 when either counter is 128 or more. When both counters are below 128, `errPassive` is 0 and `faultState` is 2'b00.
- R7: A transmit increment that takes the transmit counter above 255 sets `busOff`. The 9-bit `tecCount` then shows the value reached, `faultState` is 2'b10, and `errPassive` is 0.
- R8: While `busOff` is 1, every increment and decrement strobe is ignored and both counters hold their values.
- R9: A recovery strobe during bus-off clears both counters and `busOff`, so the node reads error-active after the next edge.
- R10: A recovery strobe outside bus-off has no effect on the counters or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| recIncEn | input | 1 | Receive counter increment strobe |
| recDecEn | input | 1 | Receive counter decrement strobe |
| recIncBig | input | 1 | Receive increment step select: 1 = step 8, 0 = step 1 |
| tecIncEn | input | 1 | Transmit counter increment strobe |
| tecDecEn | input | 1 | Transmit counter decrement strobe |
| tecIncBig | input | 1 | Transmit increment step select: 1 = step 8, 0 = step 1 |
| recoverEn | input | 1 | Bus-off recovery strobe |
| recCount | output | 8 | Receive error count |
| tecCount | output | 9 | Transmit error count, bit 8 set only in bus-off |
| faultState | output | 2 | 00 error-active, 01 error-passive, 10 bus-off |
| errPassive | output | 1 | Error-passive flag |
| busOff | output | 1 | Bus-off flag |

## Verification
Every result of this block is due one rising edge after the strobe that causes it. Both counters and the bus-off latch are single registers, and the state and flag outputs are decoded directly from them. The bench drives strobes just after a falling edge. Its behavioural model updates on the same rising edge as the design. All outputs are compared with the model on the following falling edge. A strobe's effect is therefore checked in the first cycle it should be visible, and every other cycle confirms that nothing moved unprompted.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fcState_e;

  // qualified strobes from control to datapath
  typedef struct packed {
    logic recUp;
    logic recDown;
    logic recBig;
    logic tecUp;
    logic tecDown;
    logic tecBig;
    logic clearAll;
  } fcCmd_t;

endpackage

// File: rtl/can_fc_datapath.sv
module can_fc_datapath
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BIG_STEP    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fcCmd_t           cmd,
  output logic [CNT_W-1:0] recCount,
  output logic [CNT_W:0]   tecCount,
  output logic             recHigh,
  output logic             tecHigh,
  output logic             tecOverflow
);

  localparam logic [CNT_W:0] REC_MAX  = (CNT_W+1)'((1 << CNT_W) - 1);
  localparam logic [CNT_W:0] TEC_TOP  = (CNT_W+1)'((1 << CNT_W) - 1);
  localparam logic [CNT_W:0] STEP_BIG = (CNT_W+1)'(BIG_STEP);
  localparam logic [CNT_W:0] STEP_ONE = (CNT_W+1)'(1);
  localparam logic [CNT_W:0] LIM      = (CNT_W+1)'(PASSIVE_LIM);

  logic [CNT_W-1:0] recQ, recD;
  logic [CNT_W:0]   tecQ, tecD;
  logic [CNT_W:0]   recSum, tecSum;

  always_comb begin
    recSum = {1'b0, recQ} + (cmd.recBig ? STEP_BIG : STEP_ONE);
    tecSum = tecQ + (cmd.tecBig ? STEP_BIG : STEP_ONE);
  end

  // receive counter: saturating up, floored down
  always_comb begin
    recD = recQ;
    if (cmd.clearAll) begin
      recD = '0;
    end else if (cmd.recUp) begin
      recD = (recSum > REC_MAX) ? REC_MAX[CNT_W-1:0] : recSum[CNT_W-1:0];
    end else if (cmd.recDown && recQ != '0) begin
      recD = recQ - 1'b1;
    end
  end

  // transmit counter: one extra bit carries the bus-off excursion
  always_comb begin
    tecD = tecQ;
    if (cmd.clearAll) begin
      tecD = '0;
    end else if (cmd.tecUp) begin
      tecD = tecSum;
    end else if (cmd.tecDown && tecQ != '0) begin
      tecD = tecQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recQ <= '0;
      tecQ <= '0;
    end else begin
      recQ <= recD;
      tecQ <= tecD;
    end
  end

  assign tecOverflow = cmd.tecUp && (tecSum > TEC_TOP);
  assign recHigh     = ({1'b0, recQ} >= LIM);
  assign tecHigh     = (tecQ >= LIM);
  assign recCount    = recQ;
  assign tecCount    = tecQ;

endmodule

// File: rtl/can_fc_ctrl.sv
module can_fc_ctrl
  import can_fc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       recIncEn,
  input  logic       recDecEn,
  input  logic       recIncBig,
  input  logic       tecIncEn,
  input  logic       tecDecEn,
  input  logic       tecIncBig,
  input  logic       recoverEn,
  input  logic       recHigh,
  input  logic       tecHigh,
  input  logic       tecOverflow,
  output fcCmd_t     cmd,
  output logic       busOffQ,
  output fcState_e   state
);

  logic busOffD;

  // gate strobes: frozen in bus-off, increment beats decrement
  always_comb begin
    cmd          = '0;
    cmd.recBig   = recIncBig;
    cmd.tecBig   = tecIncBig;
    cmd.clearAll = recoverEn && busOffQ;
    if (!busOffQ) begin
      cmd.recUp   = recIncEn;
      cmd.recDown = recDecEn && !recIncEn;
      cmd.tecUp   = tecIncEn;
      cmd.tecDown = tecDecEn && !tecIncEn;
    end
  end

  always_comb begin
    busOffD = busOffQ;
    if (cmd.clearAll)  busOffD = 1'b0;
    else if (tecOverflow) busOffD = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busOffQ <= 1'b0;
    else       busOffQ <= busOffD;
  end

  always_comb begin
    if (busOffQ)                state = FC_BUSOFF;
    else if (recHigh || tecHigh) state = FC_PASSIVE;
    else                         state = FC_ACTIVE;
  end

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BIG_STEP    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             recIncEn,
  input  logic             recDecEn,
  input  logic             recIncBig,
  input  logic             tecIncEn,
  input  logic             tecDecEn,
  input  logic             tecIncBig,
  input  logic             recoverEn,
  output logic [CNT_W-1:0] recCount,
  output logic [CNT_W:0]   tecCount,
  output logic [1:0]       faultState,
  output logic             errPassive,
  output logic             busOff
);

  fcCmd_t   cmd;
  fcState_e state;
  logic     recHigh, tecHigh, tecOverflow, busOffQ;

  can_fc_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .recIncEn(recIncEn), .recDecEn(recDecEn), .recIncBig(recIncBig),
    .tecIncEn(tecIncEn), .tecDecEn(tecDecEn), .tecIncBig(tecIncBig),
    .recoverEn(recoverEn),
    .recHigh(recHigh), .tecHigh(tecHigh), .tecOverflow(tecOverflow),
    .cmd(cmd), .busOffQ(busOffQ), .state(state)
  );

  can_fc_datapath #(
    .CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM), .BIG_STEP(BIG_STEP)
  ) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .recCount(recCount), .tecCount(tecCount),
    .recHigh(recHigh), .tecHigh(tecHigh), .tecOverflow(tecOverflow)
  );

  assign faultState = state;
  assign errPassive = (state == FC_PASSIVE);
  assign busOff     = busOffQ;

endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             recIncEn,
  input logic             recDecEn,
  input logic             tecIncEn,
  input logic             tecDecEn,
  input logic             recoverEn,
  input logic [CNT_W-1:0] recCount,
  input logic [CNT_W:0]   tecCount,
  input logic [1:0]       faultState,
  input logic             errPassive,
  input logic             busOff
);

  p_dec_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && recCount == '0 && recDecEn && !recIncEn) |=> recCount == '0);

  p_inc_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && tecIncEn && tecDecEn) |=> tecCount > $past(tecCount));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && recCount == '1 && recIncEn) |=> recCount == '1);

  p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    busOff |-> (!errPassive && faultState == 2'b10));

  p_enter_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOff) |-> tecCount[CNT_W]);

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && !recoverEn) |=> (busOff && $stable(recCount) && $stable(tecCount)));

  p_recover_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && recoverEn) |=> (!busOff && recCount == '0 && tecCount == '0));

  p_flags_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errPassive, busOff}));

endmodule

bind can_fault_conf can_fault_conf_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN),
  .recIncEn(recIncEn), .recDecEn(recDecEn),
  .tecIncEn(tecIncEn), .tecDecEn(tecDecEn), .recoverEn(recoverEn),
  .recCount(recCount), .tecCount(tecCount), .faultState(faultState),
  .errPassive(errPassive), .busOff(busOff)
);

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       recIncEn = 0, recDecEn = 0, recIncBig = 0;
  logic       tecIncEn = 0, tecDecEn = 0, tecIncBig = 0;
  logic       recoverEn = 0;
  logic [7:0] recCount;
  logic [8:0] tecCount;
  logic [1:0] faultState;
  logic       errPassive, busOff;

  int    nChecks = 0, nFail = 0;
  string tag = "R1";
  bit    running = 0, done = 0;

  int mRec = 0, mTec = 0;
  bit mBo = 0;

  always #2 clk = ~clk;

  can_fault_conf uut (
    .clk(clk), .rstN(rstN),
    .recIncEn(recIncEn), .recDecEn(recDecEn), .recIncBig(recIncBig),
    .tecIncEn(tecIncEn), .tecDecEn(tecDecEn), .tecIncBig(tecIncBig),
    .recoverEn(recoverEn),
    .recCount(recCount), .tecCount(tecCount), .faultState(faultState),
    .errPassive(errPassive), .busOff(busOff)
  );

  // behavioural reference, updated on the edge the design updates
  always @(posedge clk) begin
    if (!rstN) begin
      mRec = 0; mTec = 0; mBo = 0;
    end else if (mBo) begin
      if (recoverEn) begin mRec = 0; mTec = 0; mBo = 0; end
    end else begin
      if (recIncEn) begin
        mRec = mRec + (recIncBig ? 8 : 1);
        if (mRec > 255) mRec = 255;
      end else if (recDecEn && mRec > 0) mRec = mRec - 1;
      if (tecIncEn) begin
        mTec = mTec + (tecIncBig ? 8 : 1);
        if (mTec > 255) mBo = 1;
      end else if (tecDecEn && mTec > 0) mTec = mTec - 1;
    end
  end

  task automatic chk(string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      int st;
      st = mBo ? 2 : ((mRec >= 128 || mTec >= 128) ? 1 : 0);
      chk("recCount", recCount, mRec);
      chk("tecCount", tecCount, mTec);
      chk("faultState", faultState, st);
      chk("errPassive", errPassive, st == 1);
      chk("busOff", busOff, mBo);
    end
  end

  task automatic drive(input bit ri, rd, rb, ti, td, tb, rc, input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      recIncEn = ri; recDecEn = rd; recIncBig = rb;
      tecIncEn = ti; tecDecEn = td; tecIncBig = tb;
      recoverEn = rc;
    end
  endtask

  task automatic idle(input int n);
    drive(0, 0, 0, 0, 0, 0, 0, n);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired in %s", tag);
    finishRun();
  end

  initial begin
    running = 1;
    tag = "R1"; repeat (3) @(negedge clk);
    rstN = 1'b1; idle(2);

    tag = "R2"; drive(1, 0, 0, 0, 0, 0, 0, 3); drive(1, 0, 1, 0, 0, 0, 0, 2);
    drive(0, 0, 0, 1, 0, 0, 0); drive(0, 0, 0, 1, 0, 1, 0); idle(1);

    tag = "R3"; drive(1'b0, 1'b1, 0, 0, 1, 0, 0, 25); idle(1);

    tag = "R4"; drive(1, 1, 1, 1, 1, 0, 0, 2); drive(1, 1, 0, 1, 1, 1, 0); idle(1);

    tag = "R5"; drive(1, 0, 1, 0, 0, 0, 0, 40); drive(1, 0, 0, 0, 0, 0, 0, 2); idle(1);

    tag = "R6"; drive(0, 1, 0, 0, 0, 0, 0, 130); drive(1, 0, 0, 0, 0, 0, 0, 2);
    drive(0, 1, 0, 0, 0, 0, 0, 130); drive(0, 0, 0, 1, 0, 1, 0, 16);
    drive(0, 0, 0, 0, 1, 0, 0, 2); drive(0, 0, 0, 1, 0, 0, 0, 2); idle(1);

    tag = "R10"; drive(0, 0, 0, 0, 0, 0, 1, 3); idle(1);

    tag = "R7"; drive(0, 0, 0, 1, 0, 1, 0, 20); idle(2);

    tag = "R8"; drive(1, 0, 1, 1, 0, 1, 0, 3); drive(0, 1, 0, 0, 1, 0, 0, 3); idle(1);

    tag = "R9"; drive(0, 0, 0, 0, 0, 0, 1); idle(2);
    drive(0, 0, 0, 1, 0, 1, 0, 33); drive(1, 0, 0, 1, 0, 0, 1); idle(2);

    tag = "R2 R3 R7 R9 mix";
    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 9) == 0);
    end
    idle(2);
    finishRun();
  end

endmodule